// File: doc/BRIEF.md
# Pattern-Memory Window Banking and Nametable Mirroring

This block sits in a cartridge mapper between the picture processor's pattern-memory bus and an 8 KB pattern RAM. The 13-bit pattern address space is cut into eight 1 KB windows. Six bank registers decide which 1 KB page of the RAM each window reaches. The two lowest registers each cover a pair of windows, and the other four each cover a single window. The translated RAM address is purely combinational from the register state and the incoming pattern address.

The processor programs the registers with a two-step protocol. First it writes a register selector to one address. Then it writes the page number to a second address. Both steps are honoured only while the 3-bit operating mode supplied by the program-banking controller is below a limit. A separate write, accepted in every mode, selects one of four nametable mirroring arrangements for the nametable logic.

Top module: `chr_window_map`

## Requirements
- R1: After reset the six bank registers hold 0, 2, 4, 5, 6 and 7. Every window w therefore maps to page w, and `mirror_sel` reads 0.
- R2: A strobed write to address 0x8000 stores `cpu_data[3:0]` as the selector. A later strobed write to 0x8001 loads `cpu_data` into bank register s, where s is the selector and is 0..5. The new mapping is visible right after the clock edge that takes the write.
- R3: Bank register 0 drives windows 0 and 1, and bank register 1 drives windows 2 and 3. For a value V, the first window of the pair gets page V mod 8 and the second gets (V+1) mod 8. An odd V is not rounded down, and V=7 wraps the second window to page 0.
- R4: Bank registers 2..5 drive windows 4..7 in that order, each with page V mod 8. Data bits above bit 2 have no effect.
- R5: `chr_addr` equals {page of window `ppu_addr[12:10]`, `ppu_addr[9:0]`} and follows `ppu_addr` with no clock delay.
- R6: While `mode` is 5 or more, writes to 0x8000 and to 0x8001 leave both the selector and all bank registers unchanged.
- R7: A write to 0x8001 with the selector at 6..15 changes no bank register.
- R8: A strobed write to 0xA000 loads `mirror_sel` from `cpu_data[1:0]` in every mode. The codes are 0 vertical, 1 horizontal, 2 single-screen low and 3 single-screen high.
- R9: Nothing changes when `cpu_wr` is low, and writes to any other address leave the mapping and mirroring unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor write address |
| cpu_data | input | 8 | Processor write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| mode | input | 3 | Operating mode from the program-banking controller |
| ppu_addr | input | 13 | Pattern-memory address from the picture processor |
| chr_addr | output | 13 | Translated address into the 8 KB pattern RAM |
| mirror_sel | output | 2 | Nametable mirroring code |

## Verification
Every register write lands on the clock edge where `cpu_wr` is high. Its effect on `chr_addr` and `mirror_sel` is therefore due one edge after the strobe. The bench drives each write on a falling edge, lets one rising edge pass, and only then reads the outputs, well clear of the next rising edge. The translation itself has zero latency, so the bench sweeps all eight windows by changing `ppu_addr` on a falling edge and sampling one time unit later in the same cycle. It never waits for a clock before reading the translation.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;
   typedef enum logic [1:0] {
      MIR_VERT  = 2'd0,
      MIR_HORZ  = 2'd1,
      MIR_LOW   = 2'd2,
      MIR_HIGH  = 2'd3
   } mirror_e;

   localparam int SEL_W = 4;   // width of the stored register selector
endpackage

// File: rtl/chr_bank_file.sv
module chr_bank_file
   import chr_map_pkg::*;
#(
   parameter int CPU_AW     = 16,
   parameter int DW         = 8,
   parameter int PB         = 3,
   parameter int NREG       = 6,
   parameter int MODE_W     = 3,
   parameter int MODE_LIMIT = 5,
   parameter logic [CPU_AW-1:0] SEL_ADDR  = 16'h8000,
   parameter logic [CPU_AW-1:0] LOAD_ADDR = 16'h8001
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [CPU_AW-1:0]         cpu_addr,
   input  logic [DW-1:0]             cpu_data,
   input  logic                      cpu_wr,
   input  logic [MODE_W-1:0]         mode,
   output logic [NREG-1:0][PB-1:0]   banks
);
   localparam int SW = $clog2(NREG);
   localparam logic [MODE_W-1:0] LIM    = MODE_W'(MODE_LIMIT);
   localparam logic [SEL_W-1:0]  NREG_S = SEL_W'(NREG);

   if (DW < SEL_W) begin : g_chk_dw
      $error("data width too small for selector");
   end
   if (NREG > (1 << SEL_W)) begin : g_chk_nreg
      $error("more bank registers than selector codes");
   end

   logic [SEL_W-1:0] sel_q;
   logic             unlocked;
   logic             sel_wr;
   logic             load_wr;

   assign unlocked = (mode < LIM);
   assign sel_wr   = cpu_wr && unlocked && (cpu_addr == SEL_ADDR);
   assign load_wr  = cpu_wr && unlocked && (cpu_addr == LOAD_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n)      sel_q <= '0;
      else if (sel_wr) sel_q <= cpu_data[SEL_W-1:0];
   end

   for (genvar k = 0; k < NREG; k++) begin : g_bank
      // pair registers start at 0 and 2, single ones at their window number
      localparam logic [PB-1:0] RST_V = (k == 0) ? PB'(0) :
                                        (k == 1) ? PB'(2) : PB'(k + 2);
      always_ff @(posedge clk) begin
         if (!rst_n)
            banks[k] <= RST_V;
         else if (load_wr && (sel_q == SEL_W'(k)))
            banks[k] <= cpu_data[PB-1:0];
      end
   end

   // R2: an accepted load reaches the selected register on the next edge
   a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == LOAD_ADDR && mode < LIM && sel_q < NREG_S)
      |=> banks[$past(sel_q[SW-1:0])] == $past(cpu_data[PB-1:0]));

   // R6: locked modes freeze selector and registers
   a_r6_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && mode >= LIM) |=> ($stable(banks) && $stable(sel_q)));

   // R7: out-of-range selector leaves registers alone
   a_r7_high_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == LOAD_ADDR && sel_q >= NREG_S) |=> $stable(banks));

   // R9: no strobe, no change
   a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_wr |=> ($stable(banks) && $stable(sel_q)));
endmodule

// File: rtl/chr_page_xlate.sv
module chr_page_xlate #(
   parameter int WB     = 3,
   parameter int PB     = 3,
   parameter int NREG   = 6,
   parameter int PPU_AW = 13
) (
   input  logic [NREG-1:0][PB-1:0] banks,
   input  logic [PPU_AW-1:0]       ppu_addr,
   output logic [PPU_AW-1:0]       chr_addr
);
   localparam int NWIN  = 1 << WB;
   localparam int OFF_W = PPU_AW - WB;

   if (NREG != NWIN - 2) begin : g_chk_regs
      $error("register count must be window count minus two");
   end
   if (WB < 3) begin : g_chk_wb
      $error("need at least eight windows");
   end

   logic [NWIN-1:0][PB-1:0] page;

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      if (w < 4) begin : g_pair
         // pair expansion: consecutive pages, base not aligned
         assign page[w] = banks[w / 2] + PB'(w % 2);
      end else begin : g_single
         assign page[w] = banks[w - 2];
      end
   end

   assign chr_addr = {page[ppu_addr[PPU_AW-1:OFF_W]], ppu_addr[OFF_W-1:0]};
endmodule

// File: rtl/chr_mirror_reg.sv
module chr_mirror_reg
   import chr_map_pkg::*;
#(
   parameter int CPU_AW = 16,
   parameter int DW     = 8,
   parameter logic [CPU_AW-1:0] MIR_ADDR = 16'hA000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [DW-1:0]     cpu_data,
   input  logic              cpu_wr,
   output logic [1:0]        mirror_sel
);
   mirror_e mir_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         mir_q <= MIR_VERT;
      else if (cpu_wr && cpu_addr == MIR_ADDR)
         mir_q <= mirror_e'(cpu_data[1:0]);
   end

   assign mirror_sel = mir_q;

   // R8: accepted in every mode, takes the two low data bits
   a_r8_mirror_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == MIR_ADDR) |=> mirror_sel == $past(cpu_data[1:0]));

   // R9: other traffic leaves mirroring alone
   a_r9_mirror_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_wr && cpu_addr == MIR_ADDR) |=> $stable(mirror_sel));
endmodule

// File: rtl/chr_window_map.sv
module chr_window_map #(
   parameter int CPU_AW     = 16,
   parameter int DW         = 8,
   parameter int PPU_AW     = 13,
   parameter int WIN_BITS   = 3,
   parameter int MODE_W     = 3,
   parameter int MODE_LIMIT = 5,
   parameter logic [CPU_AW-1:0] SEL_ADDR  = 16'h8000,
   parameter logic [CPU_AW-1:0] LOAD_ADDR = 16'h8001,
   parameter logic [CPU_AW-1:0] MIR_ADDR  = 16'hA000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [DW-1:0]     cpu_data,
   input  logic              cpu_wr,
   input  logic [MODE_W-1:0] mode,
   input  logic [PPU_AW-1:0] ppu_addr,
   output logic [PPU_AW-1:0] chr_addr,
   output logic [1:0]        mirror_sel
);
   localparam int NWIN = 1 << WIN_BITS;
   localparam int NREG = NWIN - 2;
   localparam int PB   = WIN_BITS;   // RAM spans exactly the window space

   if (PPU_AW <= WIN_BITS) begin : g_chk_aw
      $error("pattern address narrower than window select");
   end
   if (DW < PB) begin : g_chk_page
      $error("data width too small for page number");
   end

   logic [NREG-1:0][PB-1:0] banks;

   chr_bank_file #(
      .CPU_AW(CPU_AW), .DW(DW), .PB(PB), .NREG(NREG), .MODE_W(MODE_W),
      .MODE_LIMIT(MODE_LIMIT), .SEL_ADDR(SEL_ADDR), .LOAD_ADDR(LOAD_ADDR)
   ) u_banks (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_wr(cpu_wr), .mode(mode), .banks(banks)
   );

   chr_page_xlate #(
      .WB(WIN_BITS), .PB(PB), .NREG(NREG), .PPU_AW(PPU_AW)
   ) u_xlate (
      .banks(banks), .ppu_addr(ppu_addr), .chr_addr(chr_addr)
   );

   chr_mirror_reg #(
      .CPU_AW(CPU_AW), .DW(DW), .MIR_ADDR(MIR_ADDR)
   ) u_mirror (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_wr(cpu_wr), .mirror_sel(mirror_sel)
   );
endmodule

// File: tb/chr_window_map_bench.sv
module chr_window_map_bench;
   localparam time CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_data = '0;
   logic        cpu_wr = 1'b0;
   logic [2:0]  mode = '0;
   logic [12:0] ppu_addr = '0;
   logic [12:0] chr_addr;
   logic [1:0]  mirror_sel;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [7:0] model [6];
   logic [1:0] mir_model;

   always #(CLK_P/2) clk = ~clk;

   chr_window_map u_chr_window_map (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_wr(cpu_wr), .mode(mode), .ppu_addr(ppu_addr),
      .chr_addr(chr_addr), .mirror_sel(mirror_sel)
   );

   function automatic logic [2:0] exp_page(int w);
      if (w < 4) return 3'(model[w/2] + 8'(w % 2));
      return model[w-2][2:0];
   endfunction

   task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [2:0] m);
      @(negedge clk);
      cpu_addr = a; cpu_data = d; mode = m; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0; cpu_addr = 16'h0000;
   endtask

   task automatic check_map(input string tag, input logic [9:0] off);
      for (int w = 0; w < 8; w++) begin
         logic [12:0] exp;
         @(negedge clk);
         ppu_addr = {3'(w), off};
         #1;
         exp = {exp_page(w), off};
         checks++;
         if (chr_addr !== exp) begin
            errors++;
            $display("FAIL %s window %0d chr_addr got %h expected %h", tag, w, chr_addr, exp);
         end
      end
   endtask

   task automatic check_mir(input string tag);
      #1;
      checks++;
      if (mirror_sel !== mir_model) begin
         errors++;
         $display("FAIL %s mirror_sel got %0d expected %0d", tag, mirror_sel, mir_model);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      model[0] = 0; model[1] = 2; model[2] = 4;
      model[3] = 5; model[4] = 6; model[5] = 7;
      mir_model = 2'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: identity layout after reset
      check_map("R1", 10'h000);
      check_mir("R1");

      // R2 R3 R4: every register, every data value, all windows
      for (int k = 0; k < 6; k++) begin
         for (int v = 0; v < 256; v += 5) begin
            wr(16'h8000, 8'(k), 3'(v % 5));
            wr(16'h8001, 8'(v), 3'((v + k) % 5));
            model[k] = 8'(v);
            check_map(k < 2 ? "R3" : "R4", 10'(v * 3 + k));
         end
      end
      // R3: explicit wrap and odd base
      wr(16'h8000, 8'h00, 3'd0); wr(16'h8001, 8'h07, 3'd0); model[0] = 8'h07;
      wr(16'h8000, 8'h01, 3'd4); wr(16'h8001, 8'h03, 3'd4); model[1] = 8'h03;
      check_map("R3", 10'h3FF);

      // R5: offset passes straight through within one cycle
      for (int o = 0; o < 1024; o += 97) check_map("R5", 10'(o));

      // R6: locked modes ignore both selector and load writes
      wr(16'h8000, 8'h02, 3'd0);
      for (int m = 5; m < 8; m++) begin
         wr(16'h8000, 8'h04, 3'(m));
         wr(16'h8001, 8'hAA, 3'(m));
         check_map("R6", 10'h155);
      end
      // selector must still be 2
      wr(16'h8001, 8'h01, 3'd1); model[2] = 8'h01;
      check_map("R6", 10'h0F0);

      // R7: selectors 6..15 touch nothing
      for (int s = 6; s < 16; s++) begin
         wr(16'h8000, 8'(s), 3'd2);
         wr(16'h8001, 8'h5B, 3'd2);
         check_map("R7", 10'(s * 7));
      end
      // high selector nibble is ignored: 0x13 selects register 3
      wr(16'h8000, 8'h13, 3'd0); wr(16'h8001, 8'h02, 3'd0); model[3] = 8'h02;
      check_map("R2", 10'h222);

      // R8: mirroring in every mode, upper data bits ignored
      for (int m = 0; m < 8; m++) begin
         for (int d = 0; d < 4; d++) begin
            wr(16'hA000, 8'(d | (m << 5)), 3'(m));
            mir_model = 2'(d);
            check_mir("R8");
         end
      end

      // R9: no strobe, and stray addresses, change nothing
      @(negedge clk);
      cpu_addr = 16'h8001; cpu_data = 8'h00; mode = 3'd0; cpu_wr = 1'b0;
      repeat (3) @(negedge clk);
      cpu_addr = 16'hA000; cpu_data = 8'h01;
      repeat (3) @(negedge clk);
      check_mir("R9");
      wr(16'h8002, 8'h00, 3'd0);
      wr(16'hA001, 8'h01, 3'd0);
      wr(16'h0001, 8'h00, 3'd0);
      check_map("R9", 10'h1A5);
      check_mir("R9");

      // R1: reset again restores identity and vertical mirroring
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      model[0] = 0; model[1] = 2; model[2] = 4;
      model[3] = 5; model[4] = 6; model[5] = 7;
      mir_model = 2'd0;
      check_map("R1", 10'h3C3);
      check_mir("R1");

      finish_run();
   end
endmodule